// File: doc/BRIEF.md
# Eight-Bit Compare Timer with Phase-Correct PWM

The block counts eight bits on a tick that comes from a ten-bit prescaler on the system clock or from rising edges of a slow crystal clock. A single compare value drives a waveform pin and a match event. Three counting behaviours are offered: free running with wrap, clear-on-match for frequency generation, and dual-slope phase-correct PWM whose compare value is double-buffered. An overflow flag and a match flag, each with its own mask, feed one interrupt line.

Software reaches the counter, the compare value, the control byte and the flag/mask byte through a plain register port. A write lands on the clock edge where `reg_we` is high. A read is combinational from `reg_addr`. The port has no back-pressure: every write is taken in the cycle it is presented. The crystal input is sampled through a synchronizer in the system domain, so flags and state always live on the system clock.

Register map (address: layout): 0 counter; 1 compare (the read returns the buffered value); 2 control, with bits [2:0] clock select, [3] crystal source, [5:4] mode (0 free, 1 clear-on-match, 2 phase-correct, 3 acts as free) and [7:6] pin action; 3 flags and masks, with bit 0 overflow flag, bit 1 match flag, bit 4 overflow mask and bit 5 match mask.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset every register reads 0, `wave_o` is 0 and `irq_o` is 0.
- R2: With clock select 0 the counter holds its value whatever the source bit is.
- R3: In free mode each tick adds one; a tick at 0xFF wraps to 0x00 and sets flag bit 0. A tick where the counter equals the active compare value sets flag bit 1.
- R4: In clear-on-match mode a tick where the counter equals the compare value loads 0x00 instead of incrementing, and sets flag bit 1.
- R5: In phase-correct mode the counter climbs to 0xFF, then falls to 0x00, then climbs again (…FE, FF, FE … 01, 00, 01…). Reaching 0x00 on the way down sets flag bit 0.
- R6: In phase-correct mode a compare write goes only to a buffer, and the buffer becomes active on the tick at 0xFF. In the other modes the write is active at once.
- R7: In phase-correct mode, pin action 2 drives `wave_o` low on an up-count match and high on a down-count match. Action 3 does the inverse. Action 0 leaves the pin unchanged.
- R8: In clear-on-match mode pin action 1 toggles `wave_o` on each match. In free mode, action 2 clears the pin on a match and action 3 sets it.
- R9: Clock select 1 ticks on every source pulse. Selects 2 to 7 tick once per 8, 32, 64, 128, 256 and 1024 source pulses.
- R10: With the source bit set, the source pulses are rising edges of `xtal_i`, seen after a synchronizer.
- R11: Writing 1 to a flag bit clears it and writing 0 leaves it. A flag event in the same cycle as the clearing write wins.
- R12: `irq_o` is high while any flag is set together with its mask bit. Writing address 3 loads both masks from bits 5:4.
- R13: A counter write takes effect on that edge and replaces any tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_i | input | 1 | Slow crystal clock, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| wave_o | output | 1 | Compare waveform pin |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A wrong direction bit or a misplaced turn-around shows on the counter readback within one tick. Because the bench reads the counter every cycle across a full dual-slope period, the error is caught in the same cycle. A compare buffer that is promoted early moves the `wave_o` edge by a whole half-period, and a cycle-accurate model of the pin catches that at the first misplaced match. Flag priority and prescaler faults show as a wrong flag bit or a wrong tick count after a window that is fixed at 80, 2048 or a few dozen cycles.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CLR  = 2'd1,
    MODE_PC   = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACT_OFF   = 2'd0,
    ACT_TGL   = 2'd1,
    ACT_CLRUP = 2'd2,
    ACT_SETUP = 2'd3
  } act_e;

  // control byte: [7:6] act, [5:4] mode, [3] crystal source, [2:0] select
  typedef struct packed {
    act_e       act;
    mode_e      mode;
    logic       xsrc;
    logic [2:0] csel;
  } ctl_t;

  localparam logic [1:0] ADR_CNT = 2'd0;
  localparam logic [1:0] ADR_CMP = 2'd1;
  localparam logic [1:0] ADR_CTL = 2'd2;
  localparam logic [1:0] ADR_FLG = 2'd3;
endpackage

// File: rtl/tmr8_clksel.sv
module tmr8_clksel #(
  parameter int PW   = 10,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_i,
  input  logic       xsrc,
  input  logic [2:0] csel,
  output logic       tick
);
  logic [SYNC-1:0] sync_q;
  logic            xprev_q;
  logic            xedge;
  logic            base;
  logic [PW-1:0]   pc_q;
  logic [7:0]      tap_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      xprev_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC-2:0], xtal_i};
      xprev_q <= sync_q[SYNC-1];
    end
  end

  assign xedge = sync_q[SYNC-1] & ~xprev_q;
  assign base  = xsrc ? xedge : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= '0;
    else if (base) pc_q <= pc_q + 1'b1;
  end

  for (genvar k = 0; k < 8; k++) begin : g_tap
    if (k == 0) begin : g_off
      assign tap_hit[k] = 1'b0;
    end else if (k == 1) begin : g_full
      assign tap_hit[k] = 1'b1;
    end else begin : g_div
      localparam int TW = (k == 2) ? 3 : (k == 3) ? 5 : (k == 4) ? 6 :
                          (k == 5) ? 7 : (k == 6) ? 8 : PW;
      assign tap_hit[k] = &pc_q[TW-1:0];
    end
  end

  assign tick = base & tap_hit[csel];

  AST_DIV8_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && csel == 3'd2) |=> (!tick || csel != 3'd2)); // R9
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  mode_e        mode,
  input  logic         cnt_we,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp_buf,
  output logic         up,
  output logic         match_ev,
  output logic         ovf_ev
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cmp_act;
  logic         pc;
  logic         live;
  logic         at_top;
  logic         at_bot;

  assign pc     = (mode == MODE_PC);
  assign live   = tick & ~cnt_we;
  assign at_top = (cnt == MAXV);
  assign at_bot = (cnt == '0);

  assign match_ev = live & (cnt == cmp_act);
  assign ovf_ev   = live & (pc ? (~up & at_bot) : at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (cnt_we) begin
      cnt <= wdata;
    end else if (live) begin
      if (pc) begin
        if (up && at_top)       begin cnt <= MAXV - ONE; up <= 1'b0; end
        else if (!up && at_bot) begin cnt <= ONE;        up <= 1'b1; end
        else if (up)            cnt <= cnt + ONE;
        else                    cnt <= cnt - ONE;
      end else begin
        up <= 1'b1;
        if (mode == MODE_CLR && cnt == cmp_act) cnt <= '0;
        else                                    cnt <= cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_we) cmp_buf <= wdata;
      if (cmp_we && !pc)                  cmp_act <= wdata;
      else if (pc && live && up && at_top) cmp_act <= cmp_buf;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt)); // R2
  AST_CLR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLR && match_ev) |=> (cnt == '0)); // R4
  AST_PC_TURN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc && live && up && at_top) |=> (cnt == MAXV - ONE && !up)); // R5
  AST_PC_TURN_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (pc && live && !up && at_bot) |=> (cnt == ONE && up)); // R5
  AST_CMP_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (pc && !(live && up && at_top)) |=> $stable(cmp_act)); // R6
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  act_e  act,
  input  logic  match_ev,
  input  logic  up,
  output logic  wave_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_o <= 1'b0;
    end else if (match_ev) begin
      unique case (act)
        ACT_TGL:   if (mode == MODE_CLR) wave_o <= ~wave_o;
        ACT_CLRUP: wave_o <= (mode == MODE_PC) ? ~up : 1'b0;
        ACT_SETUP: wave_o <= (mode == MODE_PC) ? up : 1'b1;
        default:   wave_o <= wave_o;
      endcase
    end
  end

  AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !match_ev |=> $stable(wave_o)); // R7
  AST_WAVE_PC_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mode == MODE_PC && act == ACT_CLRUP && up) |=> !wave_o); // R7
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int W    = 8,
  parameter int PW   = 10,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_i,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wave_o,
  output logic       irq_o
);
  ctl_t         ctl_q;
  logic [1:0]   flg_q;
  logic [1:0]   msk_q;
  logic [1:0]   flg_clr;
  logic [1:0]   flg_set;
  logic         tick;
  logic [W-1:0] cnt;
  logic [W-1:0] cmp_buf;
  logic         up;
  logic         match_ev;
  logic         ovf_ev;
  logic         unused_bits;

  assign unused_bits = ^{reg_wdata[7:6], reg_wdata[3:2]};

  tmr8_clksel #(.PW(PW), .SYNC(SYNC)) u_clksel (
    .clk(clk), .rst_n(rst_n), .xtal_i(xtal_i),
    .xsrc(ctl_q.xsrc), .csel(ctl_q.csel), .tick(tick)
  );

  tmr8_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(ctl_q.mode),
    .cnt_we(reg_we && reg_addr == ADR_CNT),
    .cmp_we(reg_we && reg_addr == ADR_CMP),
    .wdata(reg_wdata[W-1:0]), .cnt(cnt), .cmp_buf(cmp_buf), .up(up),
    .match_ev(match_ev), .ovf_ev(ovf_ev)
  );

  tmr8_wave u_wave (
    .clk(clk), .rst_n(rst_n), .mode(ctl_q.mode), .act(ctl_q.act),
    .match_ev(match_ev), .up(up), .wave_o(wave_o)
  );

  assign flg_set = {match_ev, ovf_ev};
  assign flg_clr = (reg_we && reg_addr == ADR_FLG) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      flg_q <= '0;
      msk_q <= '0;
    end else begin
      if (reg_we && reg_addr == ADR_CTL) ctl_q <= ctl_t'(reg_wdata);
      if (reg_we && reg_addr == ADR_FLG) msk_q <= reg_wdata[5:4];
      flg_q <= (flg_q & ~flg_clr) | flg_set;
    end
  end

  assign irq_o = |(flg_q & msk_q);

  always_comb begin
    unique case (reg_addr)
      ADR_CNT: reg_rdata = 8'(cnt);
      ADR_CMP: reg_rdata = 8'(cmp_buf);
      ADR_CTL: reg_rdata = ctl_q;
      default: reg_rdata = {2'b00, msk_q, 2'b00, flg_q};
    endcase
  end

  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> flg_q[0]); // R11
  AST_MATCH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> flg_q[1]); // R3
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == 2'b00) |-> !irq_o); // R12
endmodule

// File: tb/tmr8_pwm_tb.sv
module tmr8_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_i = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       wave_o;
  logic       irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr8_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .xtal_i(xtal_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wave_o(wave_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] adr;
    logic [7:0] dat;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [0:23] = '{
    '{1'b1, 2'd0, 8'hFD, 8'h00, 4'd13}, // R13 load counter
    '{1'b1, 2'd2, 8'h01, 8'h00, 4'd3},  // R3 free, select 1
    '{1'b0, 2'd0, 8'h00, 8'hFD, 4'd3},
    '{1'b0, 2'd0, 8'h00, 8'hFE, 4'd3},
    '{1'b0, 2'd0, 8'h00, 8'hFF, 4'd3},
    '{1'b0, 2'd3, 8'h00, 8'h01, 4'd3},  // R3 wrap sets overflow
    '{1'b0, 2'd3, 8'h00, 8'h03, 4'd3},  // R3 match at 0
    '{1'b1, 2'd2, 8'h00, 8'h00, 4'd2},  // R2 stop
    '{1'b0, 2'd0, 8'h00, 8'h03, 4'd2},
    '{1'b0, 2'd0, 8'h00, 8'h03, 4'd2},
    '{1'b1, 2'd3, 8'h01, 8'h00, 4'd11}, // R11 clear overflow only
    '{1'b0, 2'd3, 8'h00, 8'h02, 4'd11},
    '{1'b1, 2'd3, 8'h32, 8'h00, 4'd12}, // R12 clear match, masks on
    '{1'b0, 2'd3, 8'h00, 8'h30, 4'd12},
    '{1'b1, 2'd1, 8'h03, 8'h00, 4'd4},  // R4 compare 3
    '{1'b1, 2'd0, 8'h00, 8'h00, 4'd13},
    '{1'b1, 2'd2, 8'h51, 8'h00, 4'd4},  // R4 clear mode, toggle
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd4},
    '{1'b0, 2'd0, 8'h00, 8'h01, 4'd4},
    '{1'b0, 2'd0, 8'h00, 8'h02, 4'd4},
    '{1'b0, 2'd0, 8'h00, 8'h03, 4'd4},
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd4},  // R4 reload
    '{1'b0, 2'd3, 8'h00, 8'h32, 4'd4},
    '{1'b1, 2'd2, 8'h00, 8'h00, 4'd8}   // R8 stop
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_we = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m_cnt, m_act, m_buf;
    bit m_up, m_out, m_w;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R1");
    chk(wave_o == 1'b0, "R1", wave_o, 0);
    chk(irq_o == 1'b0, "R1", irq_o, 0);

    // vector table
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      reg_we = VEC[i].we; reg_addr = VEC[i].adr; reg_wdata = VEC[i].dat;
      #1;
      if (!VEC[i].we)
        chk(reg_rdata == VEC[i].exp, $sformatf("R%0d", VEC[i].req), reg_rdata, VEC[i].exp);
      @(posedge clk);
    end
    @(negedge clk) reg_we = 1'b0;
    chk(wave_o == 1'b1, "R8", wave_o, 1);
    chk(irq_o == 1'b1, "R12", irq_o, 1);

    // phase-correct period with buffered compare (R5, R6, R7)
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'hFD);
    wr(2'd2, 8'hA1);
    m_cnt = 8'hFD; m_up = 1'b1; m_out = 1'b1; m_act = 8'h80; m_buf = 8'h80;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      m_w = (i == 20);
      reg_we = m_w; reg_addr = m_w ? 2'd1 : 2'd0; reg_wdata = 8'h40;
      #1;
      if (!m_w) chk(reg_rdata == m_cnt, "R5", reg_rdata, m_cnt);
      chk(wave_o == m_out, "R7/R6", wave_o, m_out);
      @(posedge clk);
      if (m_cnt == m_act) m_out = !m_up;
      if (m_up && m_cnt == 8'hFF) m_act = m_buf;
      if (m_up && m_cnt == 8'hFF)       begin m_cnt = 8'hFE; m_up = 1'b0; end
      else if (!m_up && m_cnt == 8'h00) begin m_cnt = 8'h01; m_up = 1'b1; end
      else if (m_up) m_cnt = m_cnt + 8'h01;
      else           m_cnt = m_cnt - 8'h01;
      if (m_w) m_buf = 8'h40;
    end
    wr(2'd2, 8'h00);
    @(negedge clk) reg_we = 1'b0; reg_addr = 2'd3;
    #1 chk(reg_rdata[0] == 1'b1, "R5", reg_rdata[0], 1);
    rd(2'd1, 8'h40, "R6");

    // R9 divide by 8 and by 1024
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h02);
    idle(80);
    rd(2'd0, 8'd10, "R9");
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h07);
    idle(2048);
    rd(2'd0, 8'd2, "R9");
    wr(2'd2, 8'h00);

    // R10 crystal source edges
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h09);
    for (int p = 0; p < 6; p++) begin
      @(negedge clk) reg_we = 1'b0; xtal_i = 1'b1;
      repeat (4) @(negedge clk);
      xtal_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    idle(6);
    rd(2'd0, 8'd6, "R10");
    wr(2'd2, 8'h08);
    idle(3);
    rd(2'd0, 8'd6, "R2");
    wr(2'd2, 8'h00);

    // R11 set beats clear in the same cycle
    wr(2'd3, 8'h03);
    wr(2'd0, 8'hFE);
    wr(2'd2, 8'h01);
    idle(1);
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h00);
    @(negedge clk) reg_we = 1'b0; reg_addr = 2'd3;
    #1 chk(reg_rdata[0] == 1'b1, "R11", reg_rdata[0], 1);
    chk(irq_o == 1'b0, "R12", irq_o, 0);
    wr(2'd3, 8'h10);
    @(negedge clk) reg_we = 1'b0;
    chk(irq_o == 1'b1, "R12", irq_o, 1);
    wr(2'd3, 8'h03);
    @(negedge clk) reg_we = 1'b0;
    chk(irq_o == 1'b0, "R12", irq_o, 0);

    // R13 write overrides a running tick
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h55);
    rd(2'd0, 8'h55, "R13");
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h00, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule